// File: doc/BRIEF.md
# Power-Good Startup and Blanking Sequencer

This block sequences the two power-good indications of a single-phase processor core regulator. After enable, it holds the regulator reference on the boot voltage and waits for the core to settle there. The core must stay at the boot voltage for a fixed number of microsecond ticks. The block then hands the reference over to the VID code and releases the fast power-good. It then counts a long run of switching cycles before it releases the delayed power-good. Analog comparisons arrive as single-bit flags: core at boot voltage, and core inside the ±14 % window around the target. The open-drain pads sit outside the block.

The fast indication `pgFastN` is active low. The delayed indication `pgDelay` is active high. Once the reference follows the VID code, any change of the VID code or of the sleep request starts a blanking interval that lasts a fixed number of switching-cycle ticks. During blanking both indications are forced to their good levels (fast low, delayed high), so the transition does not glitch them. Dropping enable, or a supply lockout, sends the sequence back to its start.

Top module: `pg_startup_seq`

## Requirements
- R1: While `enable` is low or `uvlo` is high, from the next clock edge onward `pgFastN` is 1, `pgDelay` is 0 and `refSelVid` is 0.
- R2: After enable with no lockout, `refSelVid` stays 0 (reference on the boot voltage) and `pgFastN` stays 1 until the boot period completes, whatever the VID inputs do.
- R3: The boot period completes on the BOOT_US-th (default 10) `usTick` counted while `atBoot` is high. A cycle with `atBoot` low resets the count to zero.
- R4: When the boot period completes, `refSelVid` becomes 1 at that clock edge, and from then on `pgFastN` is 0 exactly when `inWindow` is 1 (outside blanking).
- R5: `pgDelay` first becomes 1 on the STARTUP_CYC-th (default 1007) `cycTick` after `refSelVid` rose, and then only while `inWindow` is 1. Outside blanking, `pgDelay` is never 1 while `pgFastN` is 1.
- R6: In the run phase and outside blanking, `inWindow` low gives `pgFastN` = 1 and `pgDelay` = 0 in the same cycle.
- R7: While `refSelVid` is 1, a change in the sampled `{sleepReq, vidCode}` starts blanking. From the second clock edge after the input changes, `pgFastN` is 0 and `pgDelay` is 1 for BLANK_CYC (default 62) `cycTick`s, whatever `inWindow` is.
- R8: A further change during blanking reloads the full BLANK_CYC count.
- R9: VID or sleep changes made while `refSelVid` is 0 start no blanking.
- R10: From any state, enable low restarts the whole sequence. After re-enable the boot period must complete again before `refSelVid` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Regulator enable, active high |
| uvlo | input | 1 | Supply lockout flag, active high |
| atBoot | input | 1 | Core has reached the boot voltage |
| inWindow | input | 1 | Core within ±14 % of target |
| vidCode | input | VID_W | Voltage code, watched for changes |
| sleepReq | input | 1 | Sleep request, watched for changes |
| cycTick | input | 1 | One-cycle pulse per switching cycle |
| usTick | input | 1 | One-cycle pulse per microsecond |
| pgFastN | output | 1 | Fast power-good, 0 = good |
| pgDelay | output | 1 | Delayed power-good, 1 = good |
| refSelVid | output | 1 | 1 = reference follows VID code, 0 = boot voltage |

## Verification
The assertions assume that `usTick` and `cycTick` are single-cycle pulses, and that the window and boot flags are synchronous to `clk` and settle between edges. The bench drives every input one time unit after a rising edge. It generates the ticks from a free-running clock divider, so they never sit high for two cycles in a row. VID and sleep changes are applied as single steps held for many cycles, which keeps the two-stage sampling of the change detector well defined.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_SOFT = 3'd1,
    ST_BOOT = 3'd2,
    ST_RDLY = 3'd3,
    ST_RUN  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic bootRun;   // boot-period counter may count
    logic startRun;  // startup-delay counter may count
    logic blankArm;  // blanking may be started
  } seqStrobe_t;

endpackage

// File: rtl/pgseq_tickcnt.sv
module pgseq_tickcnt #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic tick,
  output logic hit
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign hit = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (hit)    cnt <= '0;
    else if (tick)   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pgseq_datapath.sv
module pgseq_datapath
  import pgseq_pkg::*;
#(
  parameter int VID_W       = 6,
  parameter int BOOT_US     = 10,
  parameter int STARTUP_CYC = 1007,
  parameter int BLANK_CYC   = 62
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [VID_W-1:0] vidCode,
  input  logic             sleepReq,
  input  logic             usTick,
  input  logic             cycTick,
  output logic             bootHit,
  output logic             startHit,
  output logic             blankActive,
  output logic             chgSeen
);
  localparam int SW = VID_W + 1;
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [SW-1:0] smpNow, smpPrev;
  logic [BW-1:0] blankCnt;

  // two sample stages: change seen when they differ
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpNow  <= '0;
      smpPrev <= '0;
    end else begin
      smpNow  <= {sleepReq, vidCode};
      smpPrev <= smpNow;
    end
  end

  assign chgSeen = (smpNow != smpPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            blankCnt <= '0;
    else if (!strb.blankArm)              blankCnt <= '0;
    else if (chgSeen)                     blankCnt <= BW'(BLANK_CYC);
    else if (cycTick && blankCnt != '0)   blankCnt <= blankCnt - BW'(1);
  end

  assign blankActive = (blankCnt != '0);

  pgseq_tickcnt #(.LIMIT(BOOT_US)) bootCnt_i (
    .clk (clk), .rstN(rstN), .run(strb.bootRun), .tick(usTick), .hit(bootHit)
  );

  pgseq_tickcnt #(.LIMIT(STARTUP_CYC)) startCnt_i (
    .clk (clk), .rstN(rstN), .run(strb.startRun), .tick(cycTick), .hit(startHit)
  );
endmodule

// File: rtl/pgseq_control.sv
module pgseq_control
  import pgseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       uvlo,
  input  logic       atBoot,
  input  logic       inWindow,
  input  logic       bootHit,
  input  logic       startHit,
  input  logic       blankActive,
  output seqStrobe_t strb,
  output logic       pgFastN,
  output logic       pgDelay,
  output logic       refSelVid
);
  seqState_t state, stateNext;
  logic runPh;

  always_comb begin
    stateNext = state;
    if (!enable || uvlo) stateNext = ST_OFF;
    else begin
      unique case (state)
        ST_OFF:  stateNext = ST_SOFT;
        ST_SOFT: if (atBoot)   stateNext = ST_BOOT;
        ST_BOOT: if (bootHit)  stateNext = ST_RDLY;
        ST_RDLY: if (startHit) stateNext = ST_RUN;
        ST_RUN:  stateNext = ST_RUN;
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  assign runPh = (state == ST_RDLY) || (state == ST_RUN);

  always_comb begin
    strb.bootRun  = (state == ST_BOOT) && atBoot;
    strb.startRun = (state == ST_RDLY);
    strb.blankArm = runPh;
  end

  always_comb begin
    refSelVid = runPh;
    if (runPh && blankActive) begin
      pgFastN = 1'b0;
      pgDelay = 1'b1;
    end else begin
      pgFastN = !(runPh && inWindow);
      pgDelay = (state == ST_RUN) && inWindow;
    end
  end
endmodule

// File: rtl/pg_startup_seq.sv
module pg_startup_seq
  import pgseq_pkg::*;
#(
  parameter int VID_W       = 6,
  parameter int BOOT_US     = 10,
  parameter int STARTUP_CYC = 1007,
  parameter int BLANK_CYC   = 62
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             uvlo,
  input  logic             atBoot,
  input  logic             inWindow,
  input  logic [VID_W-1:0] vidCode,
  input  logic             sleepReq,
  input  logic             cycTick,
  input  logic             usTick,
  output logic             pgFastN,
  output logic             pgDelay,
  output logic             refSelVid
);
  seqStrobe_t strb;
  logic bootHit, startHit, blankActive, chgSeen;

  pgseq_datapath #(
    .VID_W(VID_W), .BOOT_US(BOOT_US),
    .STARTUP_CYC(STARTUP_CYC), .BLANK_CYC(BLANK_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .vidCode(vidCode), .sleepReq(sleepReq),
    .usTick(usTick), .cycTick(cycTick), .bootHit(bootHit), .startHit(startHit),
    .blankActive(blankActive), .chgSeen(chgSeen)
  );

  pgseq_control ctl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .uvlo(uvlo), .atBoot(atBoot),
    .inWindow(inWindow), .bootHit(bootHit), .startHit(startHit),
    .blankActive(blankActive), .strb(strb), .pgFastN(pgFastN),
    .pgDelay(pgDelay), .refSelVid(refSelVid)
  );
endmodule

// File: rtl/pgseq_checker.sv
module pgseq_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic uvlo,
  input logic atBoot,
  input logic usTick,
  input logic inWindow,
  input logic blankActive,
  input logic chgSeen,
  input logic pgFastN,
  input logic pgDelay,
  input logic refSelVid
);
  p_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!enable || uvlo) |=> (pgFastN && !pgDelay && !refSelVid));

  p_stay_boot_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!refSelVid && !(atBoot && usTick)) |=> !refSelVid);

  p_boot_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refSelVid) |-> $past(atBoot && usTick));

  p_delay_fast_r5: assert property (@(posedge clk) disable iff (!rstN)
    pgDelay |-> !pgFastN);

  p_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    (refSelVid && !blankActive && !inWindow) |-> (pgFastN && !pgDelay));

  p_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chgSeen && refSelVid && enable && !uvlo) |=> (!pgFastN && pgDelay));
endmodule

bind pg_startup_seq pgseq_checker chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .uvlo(uvlo), .atBoot(atBoot),
  .usTick(usTick), .inWindow(inWindow), .blankActive(blankActive),
  .chgSeen(chgSeen), .pgFastN(pgFastN), .pgDelay(pgDelay), .refSelVid(refSelVid)
);

// File: tb/pg_startup_seq_tb.sv
`timescale 1ns/1ps
module pg_startup_seq_tb_top;
  localparam int BOOT_US = 10, STARTUP_CYC = 1007, BLANK_CYC = 62;

  logic clk = 0, rstN = 0;
  logic enable = 0, uvlo = 0, atBoot = 0, inWindow = 0, sleepReq = 0;
  logic cycTick = 0, usTick = 0;
  logic [5:0] vidCode = 6'd0;
  logic pgFastN, pgDelay, refSelVid;

  int checks = 0, errors = 0, clkCount = 0;
  string phase = "R1";
  bit modelOn = 0;

  always #4 clk = ~clk;

  pg_startup_seq dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .uvlo(uvlo), .atBoot(atBoot),
    .inWindow(inWindow), .vidCode(vidCode), .sleepReq(sleepReq),
    .cycTick(cycTick), .usTick(usTick), .pgFastN(pgFastN),
    .pgDelay(pgDelay), .refSelVid(refSelVid)
  );

  // reference model: phase 0 off,1 soft,2 boot,3 delay,4 run
  int mPh = 0, mUs = 0, mCyc = 0, mBlank = 0, mNew = 0, mOld = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mUs = 0; mCyc = 0; mBlank = 0; mNew = 0; mOld = 0;
    end else begin
      bit changed, usDone, cycDone, armed;
      int nextPh;
      changed = (mNew != mOld);
      armed   = (mPh >= 3);
      usDone  = (mPh == 2) && atBoot && usTick && (mUs == BOOT_US - 1);
      cycDone = (mPh == 3) && cycTick && (mCyc == STARTUP_CYC - 1);
      nextPh = mPh;
      if (!enable || uvlo) nextPh = 0;
      else if (mPh == 0) nextPh = 1;
      else if (mPh == 1 && atBoot) nextPh = 2;
      else if (usDone) nextPh = 3;
      else if (cycDone) nextPh = 4;
      if (mPh == 2 && atBoot) begin
        if (usTick) mUs = usDone ? 0 : mUs + 1;
      end else mUs = 0;
      if (mPh == 3) begin
        if (cycTick) mCyc = cycDone ? 0 : mCyc + 1;
      end else mCyc = 0;
      if (!armed) mBlank = 0;
      else if (changed) mBlank = BLANK_CYC;
      else if (cycTick && mBlank > 0) mBlank = mBlank - 1;
      mOld = mNew;
      mNew = {sleepReq, vidCode};
      mPh = nextPh;
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      bit run, blanked, eFast, eDel, eRef;
      run = (mPh >= 3);
      blanked = run && (mBlank > 0);
      eRef = run;
      eFast = blanked ? 1'b0 : !(run && inWindow);
      eDel  = blanked ? 1'b1 : ((mPh == 4) && inWindow);
      checks++;
      if ({pgFastN, pgDelay, refSelVid} !== {eFast, eDel, eRef}) begin
        errors++;
        $display("FAIL %s model compare: actual fast=%b dly=%b ref=%b expected fast=%b dly=%b ref=%b",
                 phase, pgFastN, pgDelay, refSelVid, eFast, eDel, eRef);
      end
    end
  end

  // tick generator
  initial begin
    int n = 0;
    forever begin
      @(posedge clk); #1;
      n++;
      usTick  = (n % 8 == 0);
      cycTick = (n % 4 == 1);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      clkCount++;
      if (clkCount > 100000) begin
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    #3;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    clocks(3);
    rstN = 1;
    modelOn = 1;
    // R1: reset / disabled
    phase = "R1";
    chk("R1", "pgFastN off", pgFastN, 1'b1);
    chk("R1", "pgDelay off", pgDelay, 1'b0);
    enable = 1; uvlo = 1;
    clocks(5);
    chk("R1", "ref under lockout", refSelVid, 1'b0);
    // R2 and R9: enabled, no boot reached, VID moves
    phase = "R2";
    uvlo = 0;
    clocks(10);
    vidCode = 6'd5;
    clocks(4);
    chk("R9", "no blanking before run", pgFastN, 1'b1);
    chk("R2", "ref on boot", refSelVid, 1'b0);
    // R3: boot timer restart
    phase = "R3";
    atBoot = 1;
    clocks(40);
    atBoot = 0;
    clocks(3);
    atBoot = 1;
    clocks(72);
    chk("R3", "boot count restarted", refSelVid, 1'b0);
    clocks(20);
    chk("R4", "ref follows VID", refSelVid, 1'b1);
    // R4: fast pg follows window
    phase = "R4";
    chk("R4", "fast pg out of window", pgFastN, 1'b1);
    inWindow = 1;
    clocks(1);
    chk("R4", "fast pg in window", pgFastN, 1'b0);
    // R5: delayed pg
    phase = "R5";
    clocks(3800);
    chk("R5", "delayed pg before count", pgDelay, 1'b0);
    clocks(300);
    chk("R5", "delayed pg after count", pgDelay, 1'b1);
    // R6: leave window
    phase = "R6";
    inWindow = 0;
    clocks(1);
    chk("R6", "fast pg out", pgFastN, 1'b1);
    chk("R6", "delayed pg out", pgDelay, 1'b0);
    // R7: VID change blanks
    phase = "R7";
    vidCode = 6'd33;
    clocks(3);
    chk("R7", "blank fast forced", pgFastN, 1'b0);
    chk("R7", "blank delay forced", pgDelay, 1'b1);
    // R8: reload during blanking
    phase = "R8";
    clocks(200);
    vidCode = 6'd34;
    clocks(200);
    chk("R8", "still blanked after reload", pgDelay, 1'b1);
    clocks(100);
    chk("R8", "blanking ended", pgDelay, 1'b0);
    // R7: sleep change blanks as well
    phase = "R7";
    sleepReq = 1;
    clocks(3);
    chk("R7", "sleep blank fast", pgFastN, 1'b0);
    clocks(300);
    inWindow = 1;
    clocks(2);
    chk("R6", "back in window", pgDelay, 1'b1);
    // R10: disable restarts
    phase = "R10";
    enable = 0;
    clocks(2);
    chk("R10", "disabled ref", refSelVid, 1'b0);
    chk("R10", "disabled fast", pgFastN, 1'b1);
    enable = 1;
    clocks(30);
    chk("R10", "re-enabled ref boot first", refSelVid, 1'b0);
    clocks(120);
    chk("R10", "boot done again", refSelVid, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule